// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of an event timer. It watches a shared main counter that a separate block owns and advances, and it keeps a comparator value and a period value of its own. When the counter advances onto the comparator value while counting is enabled, the channel emits a single-cycle fire strobe. In one-shot mode the comparator stays where software put it. In periodic mode the channel moves the comparator forward by one period on each match, so the next match is always ahead of the counter.

Software writes the comparator through a write strobe. In periodic mode that write sets the period, and it also sets the match value only when a load-enable flag has been armed beforehand. That flag clears itself after every comparator write. When counting resumes, or when a write changes the comparator or the period while the counter runs, a periodic channel re-arms. It computes the first multiple-of-period step that lies strictly ahead of the counter. It uses a serial remainder unit for this, and the unit reports its activity on `busy_o`.

A system instantiates one channel per timer and shares the counter, enable and tick lines among them. Interrupt routing and register decode sit outside the block.

Top module: `cmp_chan`

## Requirements
- R1: After reset the comparator reads 0xFFFFFFFF, the period reads 0, the mode is one-shot (`periodic_o`=0), the load-enable flag is 0, and `fire_o` and `busy_o` are 0.
- R2: `fire_o` is high for exactly the one cycle that follows a cycle in which `tick_i`=1, the counter is live and `cnt_i` equals the comparator. It is low in every other cycle.
- R3: In one-shot mode a comparator write stores the written value as the comparator unchanged, even when that value is behind the counter. Such a value matches only after the counter wraps.
- R4: In periodic mode a comparator write stores the written value as the period. It replaces the comparator only if the load-enable flag was 1 at the write.
- R5: The load-enable flag is set by a configuration write with `cfg_vset_i`=1 and reads 0 after any comparator write.
- R6: On a periodic match the comparator becomes its previous value plus the period, modulo 2^32.
- R7: A configuration write with `cfg_periodic_i`=0 selects one-shot mode and forces the period to 0.
- R8: When `cnt_en_i` rises on a periodic channel with a nonzero period, the comparator becomes C + P − ((C − M) mod P), modulo 2^32. Here C is the frozen counter, M is the old comparator and P is the period. `busy_o` is high for at most W/DIV_BITS+1 cycles while this is computed.
- R9: A comparator write that changes the comparator or the period while the counter runs re-arms a periodic channel with a nonzero period, using the same formula against the current counter value.
- R10: A matching tick presented in the same cycle that `cnt_en_i` falls still produces one fire strobe.
- R11: A one-shot channel, or a periodic channel whose period is 0, does not re-arm. Its comparator is unchanged and `busy_o` stays low when counting resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Main counter enabled |
| tick_i | input | 1 | `cnt_i` holds a freshly advanced counter value this cycle |
| cnt_i | input | W | Shared main counter value |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_periodic_i | input | 1 | Mode on configuration write: 1 periodic, 0 one-shot |
| cfg_vset_i | input | 1 | Load-enable flag value on configuration write |
| cmp_we_i | input | 1 | Comparator write strobe |
| cmp_wdata_i | input | W | Comparator write data |
| fire_o | output | 1 | One-cycle match strobe |
| cmp_o | output | W | Current comparator value |
| period_o | output | W | Current period value |
| periodic_o | output | 1 | Current mode, 1 means periodic |
| vset_o | output | 1 | Current load-enable flag |
| busy_o | output | 1 | Re-arm computation in progress |

## Verification
The one-shot channel is tried twice. First it gets a comparator a few ticks ahead of the counter, which must fire once. Then it gets one just behind the counter near the wrap point, which must stay silent and unchanged; this separates a direct load from a silently corrected one. Periodic runs use a small period so that several matches fall in one run, and they resume the counter from a moved, frozen value. The step size and the resume formula are checked against an independently computed remainder, which tells a correct catch-up apart from a plain add or a stale comparator. Further patterns cover a period change while counting, a tick that coincides with the stop, and resumption with one-shot mode or a zero period. These show that the re-arm starts only when it should.

// File: rtl/cmp_chan_pkg.sv
package cmp_chan_pkg;

    // Phases of the serial remainder unit
    typedef enum logic [1:0] {
        DIV_IDLE = 2'd0,
        DIV_RUN  = 2'd1,
        DIV_DONE = 2'd2
    } div_phase_e;

endpackage

// File: rtl/cmp_chan_rem.sv
// Serial restoring remainder unit: DIV_BITS quotient bits per cycle.
module cmp_chan_rem
    import cmp_chan_pkg::*;
#(
    parameter int W        = 32,
    parameter int DIV_BITS = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] rem_o
);

    localparam int ITER = W / DIV_BITS;
    localparam int CW   = $clog2(ITER + 1);

    typedef struct packed {
        div_phase_e   ph;
        logic [W-1:0] rem;
        logic [W-1:0] quo;
        logic [W-1:0] dvs;
        logic [CW-1:0] cnt;
    } rem_st_t;

    rem_st_t s_d, s_q;

    always_comb begin
        logic [W:0]   trial;
        logic [W-1:0] r;
        logic [W-1:0] q;
        s_d = s_q;
        r   = s_q.rem;
        q   = s_q.quo;
        for (int i = 0; i < DIV_BITS; i++) begin
            trial = {r, q[W-1]};
            q     = {q[W-2:0], 1'b0};
            if (trial >= {1'b0, s_q.dvs}) begin
                r = trial[W-1:0] - s_q.dvs;
            end else begin
                r = trial[W-1:0];
            end
        end
        case (s_q.ph)
            DIV_RUN: begin
                s_d.rem = r;
                s_d.quo = q;
                s_d.cnt = s_q.cnt - 1'b1;
                if (s_q.cnt == CW'(1)) begin
                    s_d.ph = DIV_DONE;
                end
            end
            DIV_DONE: s_d.ph = DIV_IDLE;
            default:  s_d.ph = DIV_IDLE;
        endcase
        if (start_i) begin
            s_d.ph  = DIV_RUN;
            s_d.rem = '0;
            s_d.quo = dvd_i;
            s_d.dvs = dvs_i;
            s_d.cnt = CW'(ITER);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: DIV_IDLE, rem: '0, quo: '0, dvs: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.ph != DIV_IDLE);
    assign done_o = (s_q.ph == DIV_DONE);
    assign rem_o  = s_q.rem;

endmodule

// File: rtl/cmp_chan_hit.sv
// Match detection against the shared counter, plus enable edge tracking.
module cmp_chan_hit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         en_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] cmp_i,
    output logic         hit_o,
    output logic         rise_o
);

    logic en_d, en_q;

    always_comb begin
        en_d = en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    // A tick arriving in the cycle the counter stops is still honoured.
    assign hit_o  = tick_i && (en_i || en_q) && (cnt_i == cmp_i);
    assign rise_o = en_i && !en_q;

endmodule

// File: rtl/cmp_chan.sv
module cmp_chan #(
    parameter int W        = 32,
    parameter int DIV_BITS = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en_i,
    input  logic         tick_i,
    input  logic [W-1:0] cnt_i,
    input  logic         cfg_we_i,
    input  logic         cfg_periodic_i,
    input  logic         cfg_vset_i,
    input  logic         cmp_we_i,
    input  logic [W-1:0] cmp_wdata_i,
    output logic         fire_o,
    output logic [W-1:0] cmp_o,
    output logic [W-1:0] period_o,
    output logic         periodic_o,
    output logic         vset_o,
    output logic         busy_o
);

    localparam logic [W-1:0] CMP_RST = '1;

    typedef struct packed {
        logic [W-1:0] cmp;
        logic [W-1:0] per;
        logic [W-1:0] snap;
        logic         periodic;
        logic         vset;
        logic         fire;
    } chan_st_t;

    chan_st_t s_d, s_q;

    logic         hit, rise;
    logic         div_start, div_busy, div_done;
    logic [W-1:0] div_dvd, div_dvs, div_rem;

    cmp_chan_hit #(.W(W)) u_hit (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .en_i   (cnt_en_i),
        .cnt_i  (cnt_i),
        .cmp_i  (s_q.cmp),
        .hit_o  (hit),
        .rise_o (rise)
    );

    cmp_chan_rem #(.W(W), .DIV_BITS(DIV_BITS)) u_rem (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .dvd_i   (div_dvd),
        .dvs_i   (div_dvs),
        .busy_o  (div_busy),
        .done_o  (div_done),
        .rem_o   (div_rem)
    );

    always_comb begin
        logic [W-1:0] cmp_pre;
        logic         chg;
        s_d      = s_q;
        s_d.fire = hit;
        chg      = 1'b0;

        // Completion of a re-arm: snap holds counter + period
        if (div_done) begin
            s_d.cmp = s_q.snap - div_rem;
        end else if (hit && s_q.periodic) begin
            s_d.cmp = s_q.cmp + s_q.per;
        end
        cmp_pre = s_d.cmp;

        // Comparator write, interpreted by the current mode
        if (cmp_we_i) begin
            if (s_q.periodic) begin
                s_d.per = cmp_wdata_i;
                if (s_q.vset) begin
                    s_d.cmp = cmp_wdata_i;
                end
            end else begin
                s_d.cmp = cmp_wdata_i;
            end
            chg = (s_d.cmp != cmp_pre) || (s_d.per != s_q.per);
        end

        // Configuration write
        if (cfg_we_i) begin
            s_d.periodic = cfg_periodic_i;
            s_d.vset     = cfg_vset_i;
            if (!cfg_periodic_i) begin
                s_d.per = '0;
            end
        end
        if (cmp_we_i) begin
            s_d.vset = 1'b0;
        end

        // Re-arm request
        div_start = (rise || (chg && cnt_en_i)) && s_d.periodic && (s_d.per != '0);
        div_dvd   = cnt_i - s_d.cmp;
        div_dvs   = s_d.per;
        if (div_start) begin
            s_d.snap = cnt_i + s_d.per;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cmp: CMP_RST, per: '0, snap: '0,
                     periodic: 1'b0, vset: 1'b0, fire: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign fire_o     = s_q.fire;
    assign cmp_o      = s_q.cmp;
    assign period_o   = s_q.per;
    assign periodic_o = s_q.periodic;
    assign vset_o     = s_q.vset;
    assign busy_o     = div_busy;

endmodule

// File: rtl/cmp_chan_chk.sv
module cmp_chan_chk #(
    parameter int W        = 32,
    parameter int DIV_BITS = 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_en_i,
    input logic         tick_i,
    input logic [W-1:0] cnt_i,
    input logic         cfg_we_i,
    input logic         cmp_we_i,
    input logic [W-1:0] cmp_wdata_i,
    input logic         fire_o,
    input logic [W-1:0] cmp_o,
    input logic [W-1:0] period_o,
    input logic         periodic_o,
    input logic         vset_o,
    input logic         busy_o
);

    localparam int ITER = W / DIV_BITS;
    localparam int BW   = $clog2(ITER + 3);

    logic          en_seen;
    logic [BW-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_seen  <= 1'b0;
            busy_run <= '0;
        end else begin
            en_seen <= cnt_en_i;
            if (cmp_we_i || (cnt_en_i && !en_seen) || !busy_o) begin
                busy_run <= '0;
            end else if (busy_run != BW'(ITER + 2)) begin
                busy_run <= busy_run + 1'b1;
            end
        end
    end

    AST_FIRE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(tick_i)); // R2

    AST_ONESHOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we_i && !periodic_o) |=> (cmp_o == $past(cmp_wdata_i))); // R3

    AST_VSET_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we_i |=> !vset_o); // R5

    AST_PERIODIC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cnt_en_i && (cnt_i == cmp_o) && periodic_o && !cmp_we_i
         && !cfg_we_i && !busy_o)
        |=> (cmp_o == $past(cmp_o) + $past(period_o))); // R6

    AST_ONESHOT_NO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !periodic_o |-> (period_o == '0)); // R7

    AST_REARM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (int'(busy_run) <= ITER + 1)); // R8

endmodule

bind cmp_chan cmp_chan_chk #(.W(W), .DIV_BITS(DIV_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en_i    (cnt_en_i),
    .tick_i      (tick_i),
    .cnt_i       (cnt_i),
    .cfg_we_i    (cfg_we_i),
    .cmp_we_i    (cmp_we_i),
    .cmp_wdata_i (cmp_wdata_i),
    .fire_o      (fire_o),
    .cmp_o       (cmp_o),
    .period_o    (period_o),
    .periodic_o  (periodic_o),
    .vset_o      (vset_o),
    .busy_o      (busy_o)
);

// File: tb/cmp_chan_tb.sv
module cmp_chan_tb;

    localparam int SLOT = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en_i = 1'b0;
    logic        tick_i = 1'b0;
    logic [31:0] cnt_i = '0;
    logic        cfg_we_i = 1'b0;
    logic        cfg_periodic_i = 1'b0;
    logic        cfg_vset_i = 1'b0;
    logic        cmp_we_i = 1'b0;
    logic [31:0] cmp_wdata_i = '0;
    logic        fire_o;
    logic [31:0] cmp_o;
    logic [31:0] period_o;
    logic        periodic_o;
    logic        vset_o;
    logic        busy_o;

    int    n_checks = 0;
    int    n_errors = 0;
    int    fires = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] m_cmp, m_per;
    logic        m_periodic, m_vset, m_fire, m_en_q;

    always #5 clk = ~clk;

    cmp_chan u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cnt_en_i       (cnt_en_i),
        .tick_i         (tick_i),
        .cnt_i          (cnt_i),
        .cfg_we_i       (cfg_we_i),
        .cfg_periodic_i (cfg_periodic_i),
        .cfg_vset_i     (cfg_vset_i),
        .cmp_we_i       (cmp_we_i),
        .cmp_wdata_i    (cmp_wdata_i),
        .fire_o         (fire_o),
        .cmp_o          (cmp_o),
        .period_o       (period_o),
        .periodic_o     (periodic_o),
        .vset_o         (vset_o),
        .busy_o         (busy_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model, advanced on every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmp = 32'hFFFF_FFFF; m_per = '0; m_periodic = 0;
            m_vset = 0; m_fire = 0; m_en_q = 0;
        end else begin
            logic        hit, rise, chg;
            logic [31:0] oc, op;
            if (fire_o) fires++;
            hit  = tick_i && (cnt_en_i || m_en_q) && (cnt_i == m_cmp);
            rise = cnt_en_i && !m_en_q;
            chg  = 0;
            m_fire = hit;
            if (hit && m_periodic) m_cmp = m_cmp + m_per;
            if (cmp_we_i) begin
                oc = m_cmp; op = m_per;
                if (m_periodic) begin
                    m_per = cmp_wdata_i;
                    if (m_vset) m_cmp = cmp_wdata_i;
                end else begin
                    m_cmp = cmp_wdata_i;
                end
                chg = (m_cmp != oc) || (m_per != op);
            end
            if (cfg_we_i) begin
                m_periodic = cfg_periodic_i;
                m_vset = cfg_vset_i;
                if (!cfg_periodic_i) m_per = '0;
            end
            if (cmp_we_i) m_vset = 0;
            if ((rise || (chg && cnt_en_i)) && m_periodic && m_per != 0)
                m_cmp = cnt_i + m_per - ((cnt_i - m_cmp) % m_per);
            m_en_q = cnt_en_i;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check({cur_req, " fire R2"}, {31'd0, fire_o}, {31'd0, m_fire});
            if (!busy_o) check({cur_req, " cmp"}, cmp_o, m_cmp);
            check({cur_req, " period"}, period_o, m_per);
            check({cur_req, " mode"}, {31'd0, periodic_o}, {31'd0, m_periodic});
            check({cur_req, " vset R5"}, {31'd0, vset_o}, {31'd0, m_vset});
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_slots(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_i = cnt_i + 1; tick_i = 1;
            @(negedge clk); tick_i = 0;
            idle(SLOT - 2);
        end
    endtask

    task automatic wr_cmp(input logic [31:0] v);
        @(negedge clk); cmp_we_i = 1; cmp_wdata_i = v;
        @(negedge clk); cmp_we_i = 0;
    endtask

    task automatic wr_cfg(input logic p, input logic v);
        @(negedge clk); cfg_we_i = 1; cfg_periodic_i = p; cfg_vset_i = v;
        @(negedge clk); cfg_we_i = 0;
    endtask

    task automatic set_en(input logic b);
        @(negedge clk); cnt_en_i = b;
    endtask

    task automatic set_cnt(input logic [31:0] v);
        @(negedge clk); cnt_i = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] c, p, e;
        int base, c0;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 cmp", cmp_o, 32'hFFFF_FFFF);
        check("R1 period", period_o, 32'h0);
        check("R1 mode", {31'd0, periodic_o}, 32'h0);
        check("R1 vset", {31'd0, vset_o}, 32'h0);
        check("R1 fire", {31'd0, fire_o}, 32'h0);
        check("R1 busy", {31'd0, busy_o}, 32'h0);

        // R2/R3: one-shot ahead, then behind near wrap
        cur_req = "R3";
        set_cnt(100); set_en(1);
        wr_cmp(103);
        base = fires;
        run_slots(5);
        check("R2 one-shot fire count", 32'(fires - base), 32'd1);
        check("R3 cmp kept", cmp_o, 32'd103);
        set_cnt(32'hFFFF_FFF8);
        wr_cmp(32'hFFFF_FFF4);
        base = fires;
        run_slots(20);
        check("R3 behind no fire", 32'(fires - base), 32'd0);
        check("R3 behind uncorrected", cmp_o, 32'hFFFF_FFF4);

        // R4/R5: periodic writes with counter stopped
        cur_req = "R4";
        set_en(0);
        wr_cfg(1, 0);
        c = cmp_o;
        wr_cmp(40);
        check("R4 period loaded", period_o, 32'd40);
        check("R4 cmp kept without vset", cmp_o, c);
        wr_cfg(1, 1);
        check("R5 vset armed", {31'd0, vset_o}, 32'd1);
        wr_cmp(200);
        check("R4 cmp loaded with vset", cmp_o, 32'd200);
        check("R5 vset cleared", {31'd0, vset_o}, 32'd0);

        // R6/R8: small period, resume from zero
        cur_req = "R6";
        wr_cfg(1, 1);
        wr_cmp(6);
        set_cnt(0);
        set_en(1);
        idle(40);
        e = 32'd0 + 32'd6 - ((32'd0 - 32'd6) % 32'd6);
        check("R8 resume cmp", cmp_o, e);
        c0 = int'(cmp_o);
        base = fires;
        run_slots(30);
        check("R6 periodic fire count", 32'(fires - base), 32'((30 - c0) / 6 + 1));

        // R8: resume from a moved frozen counter
        cur_req = "R8";
        set_en(0);
        set_cnt(1000);
        c = cmp_o; p = period_o;
        set_en(1);
        @(negedge clk);
        check("R8 busy during re-arm", {31'd0, busy_o}, 32'd1);
        idle(40);
        check("R8 busy done", {31'd0, busy_o}, 32'd0);
        check("R8 re-armed cmp", cmp_o, 32'd1000 + p - ((32'd1000 - c) % p));
        run_slots(10);

        // R9: period change while counting
        cur_req = "R9";
        c = cmp_o;
        wr_cfg(1, 0);
        wr_cmp(9);
        idle(40);
        check("R9 period", period_o, 32'd9);
        check("R9 re-armed cmp", cmp_o, cnt_i + 32'd9 - ((cnt_i - c) % 32'd9));
        run_slots(20);

        // R7 and R10: back to one-shot, tick coincides with stop
        cur_req = "R10";
        wr_cfg(0, 0);
        check("R7 period cleared", period_o, 32'd0);
        check("R7 one-shot", {31'd0, periodic_o}, 32'd0);
        c = cnt_i + 2;
        wr_cmp(c);
        check("R3 one-shot load", cmp_o, c);
        run_slots(1);
        base = fires;
        @(negedge clk); cnt_i = cnt_i + 1; tick_i = 1; cnt_en_i = 0;
        @(negedge clk); tick_i = 0;
        @(negedge clk);
        check("R10 fire at stop", 32'(fires - base), 32'd1);

        // R11: no re-arm for one-shot or zero period
        cur_req = "R11";
        c = cmp_o;
        set_en(1);
        @(negedge clk);
        check("R11 one-shot no busy", {31'd0, busy_o}, 32'd0);
        idle(5);
        check("R11 one-shot cmp kept", cmp_o, c);
        set_en(0);
        wr_cfg(1, 0);
        set_en(1);
        @(negedge clk);
        check("R11 zero period no busy", {31'd0, busy_o}, 32'd0);
        idle(5);
        check("R11 zero period cmp kept", cmp_o, c);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule